// File: doc/BRIEF.md
# ISA I/O Decoder with Board Global Register

This block sits on the ISA bus side of a network adapter that can be stacked up to four boards deep in one machine. It watches the system address lines, AEN and the I/O read and write strobes. It recognises accesses to the board's 32-byte I/O window. Two base jumpers place that window at one of four locations. Inside the window it sorts each access into one of three regions: a register region shared by two register-owning chips, a 16-bit data-port region, and a reset region. The chips are a network controller and a repeater chip.

A separate global register has its own two-jumper location. It is three bits wide and cannot be read back. All boards in the stack capture every write to it. Its low two bits name the board that should answer register-region accesses. Its top bit steers that board's register region to the network controller (1) or to the repeater chip (0). Software writes the global register first, then performs its register accesses. The decode outputs are purely combinational from the address, AEN, strobes and jumpers. Only the global register holds state.

Top module: `isa_io_decoder`

## Requirements
- R1: `base_jmp` picks the 32-byte window (1 = jumper fitted). `2'b11` gives 0x300, `2'b10` gives 0x320, `2'b01` gives 0x340 and `2'b00` gives 0x360. `board_hit` is high for any address in the selected window while AEN is low, and low elsewhere.
- R2: Offsets 0x00 to 0x0F form the register region. A chip select is asserted there only while `ior_n` or `iow_n` is low.
- R3: Offsets 0x10 to 0x17 raise `data_port_hit`. There `io16_oe` is high and `io16_n` is driven 0. At any other address `io16_oe` is low and `io16_n` is released to high impedance.
- R4: Offsets 0x18 to 0x1F raise `rst_port_hit`. At most one of the register selects, `data_port_hit` and `rst_port_hit` is active at once.
- R5: While `aen` is high, no window decode output is asserted and no global register write is accepted.
- R6: The global register sits at 0x200 plus 0x20 times the index `{~greg_jmp[1], ~greg_jmp[0]}`, and it decodes on SA9..SA4. During an `iow_n` low phase with the global address it samples `sd[2:0]`. It commits the value on the rising edge of `iow_n`, visible on `board_num`/`ctrl_sel` one clock after `iow_n` is seen high.
- R7: After reset, `ctrl_sel` is 1 and `board_num` is 0.
- R8: In the register region with a strobe active and the board number matching `board_jmp`, `ctrl_cs` is asserted when `ctrl_sel` is 1 and `rptr_cs` when it is 0. The two are never active together.
- R9: When `board_num` differs from `board_jmp`, neither `ctrl_cs` nor `rptr_cs` is asserted.
- R10: A read strobe at the global address, or a write to any other address, leaves `board_num` and `ctrl_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the global register |
| rst_n | input | 1 | Active-low reset |
| sa | input | 10 | ISA address SA9..SA0 |
| aen | input | 1 | High while system DMA owns the bus |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| sd | input | 3 | Bus data bits used by the global register |
| base_jmp | input | 2 | Window base jumpers (1 = fitted) |
| greg_jmp | input | 2 | Global register location jumpers (1 = fitted) |
| board_jmp | input | 2 | This board's number |
| board_hit | output | 1 | Access falls in this board's 32-byte window |
| ctrl_cs | output | 1 | Network controller register select |
| rptr_cs | output | 1 | Repeater chip register select |
| data_port_hit | output | 1 | Data-port region decoded |
| rst_port_hit | output | 1 | Reset region decoded |
| io16_n | output | 1 | 16-bit transfer indication, 0 or high impedance |
| io16_oe | output | 1 | Drive enable of `io16_n` |
| board_num | output | 2 | Stored board number |
| ctrl_sel | output | 1 | Stored selector, 1 = network controller |

## Verification
Several properties are checked on every cycle. AEN masks all decodes. The region outputs are mutually exclusive. The 16-bit enable follows only the data-port region. A chip select implies a matching board number and the corresponding selector value. The stored bits change only one clock after a low-to-high transition of the write strobe. The concrete address map can only be shown by the bench's directed scenarios: the four window bases, the four global register locations, the boundary offsets 0x0F/0x10, 0x17/0x18 and 0x1F/0x20, and the reset value. The same holds for the exact value written and the fact that reads or foreign writes leave the register alone.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_REG  = 2'd1,
    WIN_DATA = 2'd2,
    WIN_RST  = 2'd3
  } win_kind_e;

  typedef struct packed {
    logic       ctrl_sel;
    logic [1:0] board;
  } greg_t;

  localparam greg_t GREG_RESET = '{ctrl_sel: 1'b1, board: 2'd0};

  // jumper fitted = 1; index grows as jumpers are removed
  function automatic logic [1:0] jmp_index(input logic [1:0] jmp);
    return ~jmp;
  endfunction

endpackage

// File: rtl/io_window_decode.sv
module io_window_decode
  import isa_dec_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          WIN_LOG2  = 5,
  parameter logic [9:0]  BASE_LO   = 10'h300,
  parameter logic [9:0]  BASE_STEP = 10'h020
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  input  logic [1:0]        jmp,
  output logic              in_window,
  output win_kind_e         kind
);
  localparam int N_BASES = 4;
  localparam int TAG_W   = ADDR_W - WIN_LOG2;

  logic [N_BASES-1:0] base_match;

  for (genvar i = 0; i < N_BASES; i++) begin : g_base
    localparam logic [ADDR_W-1:0] BASE_I = ADDR_W'(BASE_LO + BASE_STEP * i);
    assign base_match[i] = (addr[ADDR_W-1:WIN_LOG2] == BASE_I[ADDR_W-1:WIN_LOG2]);
  end

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = '0;

  logic [1:0] sub;
  assign sub = addr[WIN_LOG2-1 -: 2];

  always_comb begin
    in_window = !aen && base_match[jmp_index(jmp)];
    kind      = WIN_NONE;
    if (in_window) begin
      unique case (sub)
        2'b00, 2'b01: kind = WIN_REG;
        2'b10:        kind = WIN_DATA;
        default:      kind = WIN_RST;
      endcase
    end
  end

endmodule

// File: rtl/greg_store.sv
module greg_store
  import isa_dec_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          SPAN_LOG2 = 4,
  parameter logic [9:0]  GREG_LO   = 10'h200,
  parameter logic [9:0]  GREG_STEP = 10'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  input  logic              iow_n,
  input  logic [2:0]        wdata,
  input  logic [1:0]        jmp,
  output greg_t             greg
);
  localparam int N_LOC = 4;

  logic [N_LOC-1:0] loc_match;

  for (genvar i = 0; i < N_LOC; i++) begin : g_loc
    localparam logic [ADDR_W-1:0] LOC_I = ADDR_W'(GREG_LO + GREG_STEP * i);
    assign loc_match[i] = (addr[ADDR_W-1:SPAN_LOG2] == LOC_I[ADDR_W-1:SPAN_LOG2]);
  end

  logic  hit;
  logic  iow_q;
  logic  armed;
  greg_t shadow;

  assign hit = !aen && loc_match[jmp_index(jmp)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iow_q  <= 1'b1;
      armed  <= 1'b0;
      shadow <= GREG_RESET;
      greg   <= GREG_RESET;
    end else begin
      iow_q <= iow_n;
      if (!iow_n && hit) begin
        shadow <= greg_t'(wdata);
        armed  <= 1'b1;
      end else if (iow_n && !iow_q) begin
        if (armed) greg <= shadow;
        armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cs_steer.sv
module cs_steer
  import isa_dec_pkg::*;
(
  input  win_kind_e  kind,
  input  logic       strobe,
  input  greg_t      greg,
  input  logic [1:0] board_jmp,
  output logic       ctrl_cs,
  output logic       rptr_cs,
  output logic       data_hit,
  output logic       rst_hit,
  output logic       wide_oe
);
  logic reg_go;

  always_comb begin
    reg_go   = (kind == WIN_REG) && strobe && (greg.board == board_jmp);
    ctrl_cs  = reg_go && greg.ctrl_sel;
    rptr_cs  = reg_go && !greg.ctrl_sel;
    data_hit = (kind == WIN_DATA);
    rst_hit  = (kind == WIN_RST);
    wide_oe  = data_hit;
  end

endmodule

// File: rtl/isa_io_decoder.sv
module isa_io_decoder
  import isa_dec_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          WIN_LOG2  = 5,
  parameter int          GSPAN_LOG2 = 4,
  parameter logic [9:0]  BASE_LO   = 10'h300,
  parameter logic [9:0]  GREG_LO   = 10'h200,
  parameter logic [9:0]  LOC_STEP  = 10'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sa,
  input  logic              aen,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [2:0]        sd,
  input  logic [1:0]        base_jmp,
  input  logic [1:0]        greg_jmp,
  input  logic [1:0]        board_jmp,
  output logic              board_hit,
  output logic              ctrl_cs,
  output logic              rptr_cs,
  output logic              data_port_hit,
  output logic              rst_port_hit,
  output logic              io16_n,
  output logic              io16_oe,
  output logic [1:0]        board_num,
  output logic              ctrl_sel
);
  win_kind_e kind;
  greg_t     greg;
  logic      strobe;

  assign strobe = !ior_n || !iow_n;

  io_window_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .BASE_LO  (BASE_LO),
    .BASE_STEP(LOC_STEP)
  ) win_i (
    .addr     (sa),
    .aen      (aen),
    .jmp      (base_jmp),
    .in_window(board_hit),
    .kind     (kind)
  );

  greg_store #(
    .ADDR_W   (ADDR_W),
    .SPAN_LOG2(GSPAN_LOG2),
    .GREG_LO  (GREG_LO),
    .GREG_STEP(LOC_STEP)
  ) greg_i (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (sa),
    .aen  (aen),
    .iow_n(iow_n),
    .wdata(sd),
    .jmp  (greg_jmp),
    .greg (greg)
  );

  cs_steer steer_i (
    .kind     (kind),
    .strobe   (strobe),
    .greg     (greg),
    .board_jmp(board_jmp),
    .ctrl_cs  (ctrl_cs),
    .rptr_cs  (rptr_cs),
    .data_hit (data_port_hit),
    .rst_hit  (rst_port_hit),
    .wide_oe  (io16_oe)
  );

  // open-drain style: pulled low in the data region, released elsewhere
  assign io16_n    = io16_oe ? 1'b0 : 1'bz;
  assign board_num = greg.board;
  assign ctrl_sel  = greg.ctrl_sel;

endmodule

// File: rtl/isa_io_decoder_chk.sv
module isa_io_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       aen,
  input logic       iow_n,
  input logic [1:0] board_jmp,
  input logic       board_hit,
  input logic       ctrl_cs,
  input logic       rptr_cs,
  input logic       data_port_hit,
  input logic       rst_port_hit,
  input logic       io16_oe,
  input logic [1:0] board_num,
  input logic       ctrl_sel
);
  assert_aen_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> !(board_hit || ctrl_cs || rptr_cs || data_port_hit || rst_port_hit || io16_oe));

  assert_wide_only_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io16_oe |-> data_port_hit && board_hit);

  assert_regions_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_cs || rptr_cs, data_port_hit, rst_port_hit}));

  assert_steer_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_cs |-> ctrl_sel && !rptr_cs && board_hit);

  assert_steer_rptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_cs |-> !ctrl_sel && board_hit);

  assert_board_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_cs || rptr_cs) |-> (board_num == board_jmp));

  assert_commit_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({board_num, ctrl_sel}) |-> ($past(iow_n) && !$past(iow_n, 2)));

endmodule

bind isa_io_decoder isa_io_decoder_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .aen          (aen),
  .iow_n        (iow_n),
  .board_jmp    (board_jmp),
  .board_hit    (board_hit),
  .ctrl_cs      (ctrl_cs),
  .rptr_cs      (rptr_cs),
  .data_port_hit(data_port_hit),
  .rst_port_hit (rst_port_hit),
  .io16_oe      (io16_oe),
  .board_num    (board_num),
  .ctrl_sel     (ctrl_sel)
);

// File: tb/isa_io_decoder_tb_top.sv
module isa_io_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] sa = 10'h000;
  logic       aen = 1'b0;
  logic       ior_n = 1'b1;
  logic       iow_n = 1'b1;
  logic [2:0] sd = 3'd0;
  logic [1:0] base_jmp = 2'b11;
  logic [1:0] greg_jmp = 2'b11;
  logic [1:0] board_jmp = 2'b00;
  logic       board_hit, ctrl_cs, rptr_cs, data_port_hit, rst_port_hit;
  logic       io16_n, io16_oe, ctrl_sel;
  logic [1:0] board_num;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  isa_io_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
    .sd(sd), .base_jmp(base_jmp), .greg_jmp(greg_jmp), .board_jmp(board_jmp),
    .board_hit(board_hit), .ctrl_cs(ctrl_cs), .rptr_cs(rptr_cs),
    .data_port_hit(data_port_hit), .rst_port_hit(rst_port_hit),
    .io16_n(io16_n), .io16_oe(io16_oe), .board_num(board_num), .ctrl_sel(ctrl_sel)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] base_of(input logic [1:0] j);
    return 10'h300 + 10'h020 * {8'd0, ~j};
  endfunction

  function automatic logic [9:0] greg_of(input logic [1:0] j);
    return 10'h200 + 10'h020 * {8'd0, ~j};
  endfunction

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  // full write cycle to the global register, result visible on return
  task automatic greg_write(input logic [9:0] a, input logic [2:0] d, input logic dma);
    @(negedge clk);
    sa = a; sd = d; aen = dma; iow_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    iow_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    aen = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R7", "ctrl_sel after reset", ctrl_sel, 1);
    check("R7", "board_num after reset", board_num, 0);
  endtask

  task automatic t_base_map();
    for (int j = 0; j < 4; j++) begin
      logic [9:0] b;
      base_jmp = 2'(j);
      b = base_of(2'(j));
      sa = b;          settle(); check("R1", "first byte hit", board_hit, 1);
      sa = b + 10'h1F; settle(); check("R1", "last byte hit", board_hit, 1);
      sa = b + 10'h20; settle(); check("R1", "past window", board_hit, (j == 0) ? 0 : 0);
      sa = b - 10'h01; settle(); check("R1", "below window", board_hit, 0);
    end
    base_jmp = 2'b11;
  endtask

  task automatic t_regions();
    logic [9:0] offs [6] = '{10'h00, 10'h0F, 10'h10, 10'h17, 10'h18, 10'h1F};
    board_jmp = 2'b00;
    ior_n = 1'b0;
    foreach (offs[k]) begin
      logic is_reg, is_dat, is_rst;
      is_reg = offs[k] < 10'h10;
      is_dat = offs[k] >= 10'h10 && offs[k] < 10'h18;
      is_rst = offs[k] >= 10'h18;
      sa = 10'h300 + offs[k];
      settle();
      check("R2", "ctrl_cs in register region", ctrl_cs, int'(is_reg));
      check("R3", "data_port_hit", data_port_hit, int'(is_dat));
      check("R3", "io16_oe", io16_oe, int'(is_dat));
      if (is_dat) check("R3", "io16_n driven low", io16_n, 0);
      check("R4", "rst_port_hit", rst_port_hit, int'(is_rst));
    end
    ior_n = 1'b1;
    sa = 10'h305; settle();
    check("R2", "no select without strobe", ctrl_cs | rptr_cs, 0);
  endtask

  task automatic t_aen();
    aen = 1'b1; ior_n = 1'b0;
    sa = 10'h302; settle();
    check("R5", "board_hit under DMA", board_hit, 0);
    check("R5", "ctrl_cs under DMA", ctrl_cs, 0);
    sa = 10'h312; settle();
    check("R5", "io16_oe under DMA", io16_oe, 0);
    ior_n = 1'b1; aen = 1'b0;
    greg_write(10'h200, 3'b010, 1'b1);
    check("R5", "DMA write ignored", {ctrl_sel, board_num}, 3'b100);
  endtask

  task automatic t_greg_locations();
    for (int j = 0; j < 4; j++) begin
      logic [2:0] d;
      greg_jmp = 2'(j);
      d = 3'(j + 1);
      greg_write(greg_of(2'(j)) + 10'h00C, d, 1'b0);
      check("R6", "global write value", {ctrl_sel, board_num}, d);
    end
    greg_jmp = 2'b11;
    greg_write(10'h200, 3'b100, 1'b0);
    check("R6", "restore controller select", {ctrl_sel, board_num}, 3'b100);
  endtask

  task automatic t_commit_timing();
    @(negedge clk);
    sa = 10'h200; sd = 3'b011; iow_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R6", "no change while strobe low", {ctrl_sel, board_num}, 3'b100);
    iow_n = 1'b1;
    @(negedge clk);
    #1;
    check("R6", "committed one clock after rise", {ctrl_sel, board_num}, 3'b011);
  endtask

  task automatic t_steer();
    board_jmp = 2'b11;
    sa = 10'h304; iow_n = 1'b0; settle();
    check("R8", "rptr_cs when selector 0", rptr_cs, 1);
    check("R8", "ctrl_cs off when selector 0", ctrl_cs, 0);
    iow_n = 1'b1;
    greg_write(10'h200, 3'b111, 1'b0);
    sa = 10'h304; ior_n = 1'b0; settle();
    check("R8", "ctrl_cs when selector 1", ctrl_cs, 1);
    check("R8", "rptr_cs off when selector 1", rptr_cs, 0);
    ior_n = 1'b1;
  endtask

  task automatic t_mismatch();
    board_jmp = 2'b01;
    sa = 10'h30A; ior_n = 1'b0; settle();
    check("R9", "no select on other board", ctrl_cs | rptr_cs, 0);
    check("R9", "window still hit", board_hit, 1);
    ior_n = 1'b1;
    board_jmp = 2'b11;
  endtask

  task automatic t_ignored();
    @(negedge clk);
    sa = 10'h200; sd = 3'b000; ior_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ior_n = 1'b1;
    settle(); settle();
    check("R10", "read strobe leaves register", {ctrl_sel, board_num}, 3'b111);
    greg_write(10'h220, 3'b000, 1'b0);
    check("R10", "write elsewhere leaves register", {ctrl_sel, board_num}, 3'b111);
    greg_write(10'h300, 3'b000, 1'b0);
    check("R10", "window write leaves register", {ctrl_sel, board_num}, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;
    settle();
    t_reset();
    t_base_map();
    t_regions();
    t_aen();
    t_greg_locations();
    t_commit_timing();
    t_steer();
    t_mismatch();
    t_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule